// File: doc/BRIEF.md
# Display Path Flush Controller

This block holds the software-visible update state for one display control path. Software writes a main flush word plus two secondary masks: one for the 3D-merge units and one for the output interfaces. The block keeps them as pending bits until a frame-boundary strobe arrives. On that strobe it emits the whole pending set as one-cycle update pulses, one bit per unit, and then clears it. Two bits of the main word act as gates: the merge mask is applied only when bit 23 is pending, and the interface mask only when bit 31 is pending.

A start register fires a one-cycle start pulse. A prepare register arms a trigger flag, which stays set until the next frame boundary. Writing the software-reset register raises a busy bit. The block clears that bit by itself after a fixed number of clock cycles, and software is expected to poll it. While busy, all pending flush state is held empty and flush writes are dropped. Four plain configuration words (path mode, merge enables, interface enables, fetch enables) are stored and driven out. The register port is a single-cycle write with combinational read data.

Top module: `disp_path_flush`

## Requirements
- R1: After reset every pulse output, `trigger_armed` and `reset_busy` are 0, and each flush register reads 0.
- R2: Writes to the main flush word (0x018) OR into the pending main mask. The mask reads back at 0x018 until the next frame strobe.
- R3: A frame strobe sampled at clock edge E drives `flush_pulse` with the pending main mask for exactly the cycle after E, and clears that mask.
- R4: On a frame strobe, `merge_pulse` carries the pending merge mask (written at 0x100, bit i = merge unit i) only if bit 23 of the pending main mask is set, and is 0 otherwise. The merge mask is cleared in both cases.
- R5: On a frame strobe, `intf_pulse` carries the pending interface mask (written at 0x110, bit i = interface i) only if bit 31 of the pending main mask is set, and is 0 otherwise. The interface mask is cleared in both cases.
- R6: A flush write in the same cycle as a frame strobe is not part of that strobe's pulses. It stays pending for the next strobe.
- R7: Writing a value with bit 0 = 1 to 0x01C gives one cycle of `start_pulse`. Writing bit 0 = 0 gives none.
- R8: Writing bit 0 = 1 to 0x0D0 sets `trigger_armed`, which reads back as bit 0 of 0x0D0. A later frame strobe clears it.
- R9: Writing bit 0 = 1 to 0x030 makes bit 0 of 0x030 and `reset_busy` read 1 for exactly RST_CYCLES cycles, then 0.
- R10: Starting a reset clears all pending flush masks. While busy, writes to 0x018, 0x100 and 0x110 are ignored and a frame strobe gives no pulses.
- R11: Words written to 0x014, 0x0E4, 0x0F4 and 0x0FC are stored, read back and driven on `top_cfg`, `merge_active`, `intf_active` and `fetch_active`; the enables keep only their low N_MERGE or N_INTF bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_strobe | input | 1 | Frame-boundary strobe |
| flush_pulse | output | 32 | Per-bit main flush pulses |
| merge_pulse | output | N_MERGE | Per-unit merge flush pulses |
| intf_pulse | output | N_INTF | Per-interface flush pulses |
| start_pulse | output | 1 | Start pulse |
| trigger_armed | output | 1 | Prepare trigger flag |
| reset_busy | output | 1 | Software reset in progress |
| top_cfg | output | 32 | Path mode word |
| merge_active | output | N_MERGE | Merge unit enables |
| intf_active | output | N_INTF | Interface enables |
| fetch_active | output | 32 | Fetch pipe enables |

## Verification
Every register changes at the clock edge that samples a write. Read data is combinational, so a value written at edge E can be read in the low phase right after E. The pulses and `start_pulse` rise at the edge that samples the strobe or the start write, and they fall one edge later. The bench therefore checks them at the next falling edge, and once more one cycle on to confirm they have dropped. The busy bit counts from the edge that samples the reset write, and the bench samples it once per falling edge, expecting exactly RST_CYCLES ones before the first zero.

// File: rtl/disp_flush_pkg.sv
// Package: register addresses and gate bit positions shared by the flush
// controller, its checker and its bench. Assumes byte addressing, 32-bit words.
package disp_flush_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_FLUSH_MAIN  = 12'h018;
    localparam logic [ADDR_W-1:0] A_MERGE_FLUSH = 12'h100;
    localparam logic [ADDR_W-1:0] A_OUT_FLUSH   = 12'h110;
    localparam logic [ADDR_W-1:0] A_GO          = 12'h01C;
    localparam logic [ADDR_W-1:0] A_ARM         = 12'h0D0;
    localparam logic [ADDR_W-1:0] A_SOFT_RST    = 12'h030;
    localparam logic [ADDR_W-1:0] A_PATH_MODE   = 12'h014;
    localparam logic [ADDR_W-1:0] A_MERGE_EN    = 12'h0E4;
    localparam logic [ADDR_W-1:0] A_OUT_EN      = 12'h0F4;
    localparam logic [ADDR_W-1:0] A_FETCH_EN    = 12'h0FC;
    localparam int MERGE_GATE_BIT = 23;
    localparam int OUT_GATE_BIT   = 31;
endpackage

// File: rtl/dpf_gated_mask.sv
// Secondary pending mask: accumulates written unit bits and, on a frame
// strobe, emits them as a one-cycle pulse only if the gate bit is pending.
// Assumes clr dominates both write and strobe.
module dpf_gated_mask #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic         apply,
    input  logic         gate,
    output logic [W-1:0] pend,
    output logic [W-1:0] pulse
);
    // Pending bits: strobe clears, a same-cycle write survives, clr empties.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend <= '0;
        else
            pend <= (apply ? '0 : pend) | (wr_en ? wr_bits : '0);
    end

    // Update pulse: one cycle of the pending bits when gated on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= '0;
        else
            pulse <= (apply && gate) ? pend : '0;
    end
endmodule

// File: rtl/dpf_main_flush.sv
// Main flush word, start pulse and prepare flag. Assumes the write strobes
// are already address-decoded and clr marks reset start or reset busy.
module dpf_main_flush (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_main,
    input  logic        wr_go,
    input  logic        wr_arm,
    input  logic [31:0] wdata,
    input  logic        strobe,
    output logic [31:0] pend_main,
    output logic [31:0] flush_pulse,
    output logic        start_pulse,
    output logic        armed
);
    // Pending main mask with accumulate, strobe clear and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend_main <= '0;
        else
            pend_main <= (strobe ? 32'd0 : pend_main) | (wr_main ? wdata : 32'd0);
    end

    // Main pulses for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_pulse <= '0;
        else
            flush_pulse <= strobe ? pend_main : 32'd0;
    end

    // Start pulse from a write of bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_pulse <= 1'b0;
        else
            start_pulse <= wr_go && wdata[0];
    end

    // Prepare flag: set by write, cleared by strobe or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            armed <= 1'b0;
        else if (wr_arm && wdata[0])
            armed <= 1'b1;
        else if (strobe)
            armed <= 1'b0;
    end
endmodule

// File: rtl/dpf_reset_timer.sv
// Self-clearing software reset: a request loads a down-counter and busy holds
// while it is non-zero. Requests while busy are ignored. Assumes RST_CYCLES >= 1.
module dpf_reset_timer #(
    parameter int RST_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic start,
    output logic busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    logic [CW-1:0] cnt;

    assign busy  = (cnt != '0);
    assign start = req && !busy;

    // Down-counter for the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(RST_CYCLES);
        else if (busy)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/dpf_cfg_regs.sv
// Plain configuration storage: path mode, merge and interface enables, fetch
// enables. Assumes write strobes are address-decoded.
module dpf_cfg_regs #(
    parameter int N_MERGE = 4,
    parameter int N_INTF  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mode,
    input  logic               wr_menb,
    input  logic               wr_ienb,
    input  logic               wr_fetch,
    input  logic [31:0]        wdata,
    output logic [31:0]        top_cfg,
    output logic [N_MERGE-1:0] merge_active,
    output logic [N_INTF-1:0]  intf_active,
    output logic [31:0]        fetch_active
);
    // Store each word on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_cfg      <= '0;
            merge_active <= '0;
            intf_active  <= '0;
            fetch_active <= '0;
        end else begin
            if (wr_mode)  top_cfg      <= wdata;
            if (wr_menb)  merge_active <= wdata[N_MERGE-1:0];
            if (wr_ienb)  intf_active  <= wdata[N_INTF-1:0];
            if (wr_fetch) fetch_active <= wdata;
        end
    end
endmodule

// File: rtl/disp_path_flush.sv
// Top: decodes the register port, holds pending flushes per frame and drives
// unit update pulses. Assumes N_MERGE and N_INTF are each 1..32.
module disp_path_flush
    import disp_flush_pkg::*;
#(
    parameter int N_MERGE    = 4,
    parameter int N_INTF     = 8,
    parameter int RST_CYCLES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               frame_strobe,
    output logic [31:0]        flush_pulse,
    output logic [N_MERGE-1:0] merge_pulse,
    output logic [N_INTF-1:0]  intf_pulse,
    output logic               start_pulse,
    output logic               trigger_armed,
    output logic               reset_busy,
    output logic [31:0]        top_cfg,
    output logic [N_MERGE-1:0] merge_active,
    output logic [N_INTF-1:0]  intf_active,
    output logic [31:0]        fetch_active
);
    logic [31:0]        pend_main;
    logic [N_MERGE-1:0] pend_merge;
    logic [N_INTF-1:0]  pend_intf;
    logic               rst_start;
    logic               clr;

    // Write decode.
    logic wr_main, wr_merge, wr_intf, wr_go, wr_arm, wr_rst;
    logic wr_mode, wr_menb, wr_ienb, wr_fetch;
    assign wr_main  = bus_wr && (bus_addr == A_FLUSH_MAIN);
    assign wr_merge = bus_wr && (bus_addr == A_MERGE_FLUSH);
    assign wr_intf  = bus_wr && (bus_addr == A_OUT_FLUSH);
    assign wr_go    = bus_wr && (bus_addr == A_GO);
    assign wr_arm   = bus_wr && (bus_addr == A_ARM);
    assign wr_rst   = bus_wr && (bus_addr == A_SOFT_RST);
    assign wr_mode  = bus_wr && (bus_addr == A_PATH_MODE);
    assign wr_menb  = bus_wr && (bus_addr == A_MERGE_EN);
    assign wr_ienb  = bus_wr && (bus_addr == A_OUT_EN);
    assign wr_fetch = bus_wr && (bus_addr == A_FETCH_EN);

    assign clr = rst_start || reset_busy;

    dpf_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .req(wr_rst && bus_wdata[0]),
        .start(rst_start), .busy(reset_busy)
    );

    dpf_main_flush u_main (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_main(wr_main),
        .wr_go(wr_go), .wr_arm(wr_arm), .wdata(bus_wdata),
        .strobe(frame_strobe), .pend_main(pend_main),
        .flush_pulse(flush_pulse), .start_pulse(start_pulse),
        .armed(trigger_armed)
    );

    // One gated secondary mask per unit family.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_sec
            if (g == 0) begin : g_merge
                dpf_gated_mask #(.W(N_MERGE)) u_mask (
                    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_merge),
                    .wr_bits(bus_wdata[N_MERGE-1:0]), .apply(frame_strobe),
                    .gate(pend_main[MERGE_GATE_BIT]), .pend(pend_merge),
                    .pulse(merge_pulse)
                );
            end else begin : g_intf
                dpf_gated_mask #(.W(N_INTF)) u_mask (
                    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_intf),
                    .wr_bits(bus_wdata[N_INTF-1:0]), .apply(frame_strobe),
                    .gate(pend_main[OUT_GATE_BIT]), .pend(pend_intf),
                    .pulse(intf_pulse)
                );
            end
        end
    endgenerate

    dpf_cfg_regs #(.N_MERGE(N_MERGE), .N_INTF(N_INTF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_menb(wr_menb),
        .wr_ienb(wr_ienb), .wr_fetch(wr_fetch), .wdata(bus_wdata),
        .top_cfg(top_cfg), .merge_active(merge_active),
        .intf_active(intf_active), .fetch_active(fetch_active)
    );

    // Read mux; unmapped addresses return zero.
    always_comb begin
        case (bus_addr)
            A_FLUSH_MAIN:  bus_rdata = pend_main;
            A_MERGE_FLUSH: bus_rdata = 32'(pend_merge);
            A_OUT_FLUSH:   bus_rdata = 32'(pend_intf);
            A_ARM:         bus_rdata = 32'(trigger_armed);
            A_SOFT_RST:    bus_rdata = 32'(reset_busy);
            A_PATH_MODE:   bus_rdata = top_cfg;
            A_MERGE_EN:    bus_rdata = 32'(merge_active);
            A_OUT_EN:      bus_rdata = 32'(intf_active);
            A_FETCH_EN:    bus_rdata = fetch_active;
            default:       bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/dpf_checker.sv
// Checker: temporal properties of the flush controller ports.
module dpf_checker
    import disp_flush_pkg::*;
#(
    parameter int N_MERGE = 4,
    parameter int N_INTF  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               wdata0,
    input logic               frame_strobe,
    input logic [31:0]        flush_pulse,
    input logic [N_MERGE-1:0] merge_pulse,
    input logic [N_INTF-1:0]  intf_pulse,
    input logic               start_pulse,
    input logic               trigger_armed,
    input logic               reset_busy
);
    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pulse != '0) |-> $past(frame_strobe)); // R3
    AST_MERGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_pulse != '0) |-> flush_pulse[MERGE_GATE_BIT]); // R4
    AST_INTF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (intf_pulse != '0) |-> flush_pulse[OUT_GATE_BIT]); // R5
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bus_wr && bus_addr == A_GO && wdata0)); // R7
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_strobe) && !$past(bus_wr && bus_addr == A_ARM && wdata0))
        |-> !trigger_armed); // R8
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reset_busy) |-> (flush_pulse == '0 && merge_pulse == '0 && intf_pulse == '0)); // R10
endmodule

bind disp_path_flush dpf_checker #(.N_MERGE(N_MERGE), .N_INTF(N_INTF)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .wdata0(bus_wdata[0]), .frame_strobe(frame_strobe),
    .flush_pulse(flush_pulse), .merge_pulse(merge_pulse),
    .intf_pulse(intf_pulse), .start_pulse(start_pulse),
    .trigger_armed(trigger_armed), .reset_busy(reset_busy)
);

// File: tb/disp_path_flush_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, inputs driven and outputs sampled on
// the falling edge.
module disp_path_flush_test;
    import disp_flush_pkg::*;
    localparam int NM = 4;
    localparam int NI = 8;
    localparam int RC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              frame_strobe = 1'b0;
    logic [31:0]       flush_pulse;
    logic [NM-1:0]     merge_pulse;
    logic [NI-1:0]     intf_pulse;
    logic              start_pulse, trigger_armed, reset_busy;
    logic [31:0]       top_cfg, fetch_active;
    logic [NM-1:0]     merge_active;
    logic [NI-1:0]     intf_active;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    disp_path_flush #(.N_MERGE(NM), .N_INTF(NI), .RST_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_strobe(frame_strobe), .flush_pulse(flush_pulse),
        .merge_pulse(merge_pulse), .intf_pulse(intf_pulse),
        .start_pulse(start_pulse), .trigger_armed(trigger_armed),
        .reset_busy(reset_busy), .top_cfg(top_cfg),
        .merge_active(merge_active), .intf_active(intf_active),
        .fetch_active(fetch_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_FLUSH_MAIN, v);  check("R1 main", v, 0);
        rd(A_MERGE_FLUSH, v); check("R1 merge", v, 0);
        rd(A_OUT_FLUSH, v);   check("R1 intf", v, 0);
        check("R1 pulses", {flush_pulse | 32'(merge_pulse) | 32'(intf_pulse)}, 0);
        check("R1 flags", {29'd0, start_pulse, trigger_armed, reset_busy}, 0);
    endtask

    task automatic t_accumulate();
        logic [31:0] v;
        bw(A_FLUSH_MAIN, 32'h0000_0041);
        bw(A_FLUSH_MAIN, 32'h0002_0000);
        rd(A_FLUSH_MAIN, v); check("R2 accumulate", v, 32'h0002_0041);
        strobe();
        check("R3 pulse", flush_pulse, 32'h0002_0041);
        @(negedge clk);
        check("R3 one cycle", flush_pulse, 0);
        rd(A_FLUSH_MAIN, v); check("R3 cleared", v, 0);
    endtask

    task automatic t_merge_gate();
        logic [31:0] v;
        bw(A_MERGE_FLUSH, 32'h5);
        bw(A_OUT_FLUSH, 32'h81);
        bw(A_FLUSH_MAIN, 32'h0080_0001);
        strobe();
        check("R4 merge applied", 32'(merge_pulse), 32'h5);
        check("R5 intf gated off", 32'(intf_pulse), 0);
        rd(A_MERGE_FLUSH, v); check("R4 merge cleared", v, 0);
        rd(A_OUT_FLUSH, v);   check("R5 intf cleared", v, 0);
    endtask

    task automatic t_intf_gate();
        bw(A_OUT_FLUSH, 32'h3);
        bw(A_MERGE_FLUSH, 32'h2);
        bw(A_FLUSH_MAIN, 32'h8000_0000);
        strobe();
        check("R5 intf applied", 32'(intf_pulse), 32'h3);
        check("R4 merge gated off", 32'(merge_pulse), 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        bw(A_FLUSH_MAIN, 32'h10);
        @(negedge clk);
        bus_addr = A_FLUSH_MAIN; bus_wdata = 32'h200; bus_wr = 1'b1; frame_strobe = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frame_strobe = 1'b0;
        check("R6 old pulse only", flush_pulse, 32'h10);
        rd(A_FLUSH_MAIN, v); check("R6 kept", v, 32'h200);
        strobe();
        check("R6 next frame", flush_pulse, 32'h200);
    endtask

    task automatic t_start();
        bw(A_GO, 32'h1);
        check("R7 start", 32'(start_pulse), 1);
        @(negedge clk);
        check("R7 start one cycle", 32'(start_pulse), 0);
        bw(A_GO, 32'h2);
        check("R7 bit0 zero", 32'(start_pulse), 0);
    endtask

    task automatic t_prepare();
        logic [31:0] v;
        bw(A_ARM, 32'h1);
        check("R8 armed", 32'(trigger_armed), 1);
        rd(A_ARM, v); check("R8 readback", v, 1);
        strobe();
        check("R8 cleared", 32'(trigger_armed), 0);
    endtask

    task automatic t_busy_window();
        logic [31:0] v;
        bw(A_SOFT_RST, 32'h1);
        for (int k = 0; k < RC; k++) begin
            rd(A_SOFT_RST, v); check("R9 busy", v, 1);
            @(negedge clk);
        end
        rd(A_SOFT_RST, v); check("R9 done", v, 0);
        check("R9 port done", 32'(reset_busy), 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        bw(A_FLUSH_MAIN, 32'h8080_00FF);
        bw(A_MERGE_FLUSH, 32'h1);
        bw(A_SOFT_RST, 32'h1);
        bw(A_FLUSH_MAIN, 32'h3);
        bw(A_OUT_FLUSH, 32'h4);
        strobe();
        check("R10 no pulse", flush_pulse | 32'(merge_pulse) | 32'(intf_pulse), 0);
        rd(A_FLUSH_MAIN, v); check("R10 write dropped", v, 0);
        repeat (RC) @(negedge clk);
        check("R10 idle", 32'(reset_busy), 0);
        rd(A_FLUSH_MAIN, v);   check("R10 main cleared", v, 0);
        rd(A_MERGE_FLUSH, v);  check("R10 merge cleared", v, 0);
        rd(A_OUT_FLUSH, v);    check("R10 intf cleared", v, 0);
        bw(A_FLUSH_MAIN, 32'h4);
        rd(A_FLUSH_MAIN, v);   check("R10 writes resume", v, 32'h4);
        strobe();
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        bw(A_PATH_MODE, 32'hDEAD_BEEF);
        bw(A_MERGE_EN, 32'hFFFF_FFFF);
        bw(A_OUT_EN, 32'h1234_56A5);
        bw(A_FETCH_EN, 32'h000F_000F);
        check("R11 mode out", top_cfg, 32'hDEAD_BEEF);
        check("R11 merge en", 32'(merge_active), 32'hF);
        check("R11 intf en", 32'(intf_active), 32'hA5);
        check("R11 fetch out", fetch_active, 32'h000F_000F);
        rd(A_MERGE_EN, v);  check("R11 merge readback", v, 32'hF);
        rd(A_PATH_MODE, v); check("R11 mode readback", v, 32'hDEAD_BEEF);
        rd(12'h200, v);     check("R11 unmapped", v, 0);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accumulate();
        t_merge_gate();
        t_intf_gate();
        t_collide();
        t_start();
        t_prepare();
        t_busy_window();
        t_busy_ignore();
        t_cfg();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule